// File: doc/BRIEF.md
# Endpoint FIFO Status and Error Flags

This block holds one endpoint's word-wide data FIFO together with the status logic that watches it. The CPU pushes 32-bit words into the FIFO, and the USB side pulls them out with read requests. Software can also load the FIFO's read and write pointers directly. Two sticky error flags record misuse. The first, the bad-pointer flag, sets when a pointer load names a word address outside the FIFO storage. The second, the starved-read flag, sets when the USB side asks for data from an empty FIFO and must be held in wait states. Software clears each flag by writing a one to its bit of the status word.

Each pushed word can carry a frame-end mark and the byte lane of its last byte. While that word sits at the head of the FIFO, the status word shows the lane as a one-hot code. Each flag feeds a registered FIFO error output, and each flag has its own mask input, so the interrupt logic downstream sees only the causes it has enabled.

Top module: `ep_fifo_status`

## Requirements
- R1: After reset the status word reads 0x0001_0000 (only the empty bit, bit 16, is set), `fifo_err` is 0 and `pop_ok` is 0.
- R2: Words leave the FIFO in the order they were pushed, and `pop_data` always shows the head word. A push while DEPTH words are held is dropped.
- R3: Status bit 16 (empty) is 1 exactly when the FIFO holds no word. It follows the contents in the same cycle they change and is not sticky.
- R4: A pointer load with a value of DEPTH or more sets status bit 31 (bad pointer) on the next edge and leaves both pointers unchanged.
- R5: A legal pointer load (`ptr_sel` 0 = write pointer, 1 = read pointer) moves that pointer and keeps the stored data. The held count becomes (write pointer − read pointer) mod DEPTH, so equal pointers mean empty. Push and pop are ignored in a cycle with a pointer load.
- R6: A pop request while empty raises `pop_wait` in the same cycle, sets status bit 30 (starved read) on the next edge, and removes nothing.
- R7: A status write with bit 31 or bit 30 set clears that flag. A zero in either bit leaves the flag as it was.
- R8: When a flag's set condition and its clearing write fall in the same cycle, the flag is 1 afterwards.
- R9: `fifo_err` is registered. One edge after any change, it equals (bad-pointer AND NOT `mask_bad_ptr`) OR (starved-read AND NOT `mask_starve`).
- R10: Status bits 27:24 show the head word's frame-end lane as one-hot: lane 3 (bits 31:24) gives 1000, lane 2 gives 0100, lane 1 gives 0010 and lane 0 gives 0001. The field is 0000 when the head word has no frame-end mark or the FIFO is empty.
- R11: Status bits 29:28, 23:17 and 15:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_en | input | 1 | Push one word into the FIFO |
| push_data | input | 32 | Word to push |
| push_eof | input | 1 | Pushed word holds a frame end |
| push_lane | input | 2 | Byte lane of the frame end (3 = bits 31:24) |
| pop_req | input | 1 | USB-side read request |
| pop_data | output | 32 | Head word of the FIFO |
| pop_ok | output | 1 | The request is served on this edge |
| pop_wait | output | 1 | The request is stalled because the FIFO is empty |
| ptr_we | input | 1 | Load a user-visible pointer |
| ptr_sel | input | 1 | 0 = write pointer, 1 = read pointer |
| ptr_wdata | input | PTR_IN_W | Word address to load |
| stat_we | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 32 | Status write data |
| mask_bad_ptr | input | 1 | Keeps the bad-pointer flag off `fifo_err` |
| mask_starve | input | 1 | Keeps the starved-read flag off `fifo_err` |
| status | output | 32 | Status word |
| fifo_err | output | 1 | Registered, masked OR of the error flags |

## Verification
A wrong pointer or count shows up at once as a wrong `pop_data` word, a wrong frame-lane code or a wrong empty bit. The sweep loads every possible pointer value and drains every stored word, so such a fault appears on the first affected word. A flag that is dropped, or set when it should not be, is seen on the status word one edge after its cause. A fault in the masking or in the error register appears on `fifo_err` one edge after that, and the bench walks through every mask combination with each set of flags.

// File: rtl/ep_fsr_pkg.sv
package ep_fsr_pkg;

    localparam int BIT_BAD_PTR = 31;
    localparam int BIT_STARVE  = 30;
    localparam int FRM_LSB     = 24;
    localparam int BIT_EMPTY   = 16;

    typedef struct packed {
        logic [31:0] data;
        logic        eof;
        logic [1:0]  lane;
    } fifo_entry_t;

    function automatic logic [3:0] lane_onehot(input logic [1:0] lane);
        return 4'b0001 << lane;
    endfunction

endpackage

// File: rtl/ep_fifo_store.sv
module ep_fifo_store
    import ep_fsr_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int PTR_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_en,
    input  fifo_entry_t         push_entry,
    input  logic                pop_req,
    input  logic                ptr_we,
    input  logic                ptr_sel,
    input  logic [PTR_IN_W-1:0] ptr_wdata,
    output fifo_entry_t         head,
    output logic                empty,
    output logic                pop_ok,
    output logic                ptr_bad
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    fifo_entry_t mem_d [DEPTH];
    fifo_entry_t mem_q [DEPTH];

    logic             has_room;
    logic             push_ok;
    logic [PTR_W-1:0] new_wp, new_rp;

    always_comb begin
        empty    = (ctl_q.cnt == '0);
        has_room = (ctl_q.cnt < CNT_W'(DEPTH));
        ptr_bad  = ptr_we && (ptr_wdata >= PTR_IN_W'(DEPTH));
        pop_ok   = pop_req && !empty && !ptr_we;
        push_ok  = push_en && has_room && !ptr_we;
        head     = mem_q[ctl_q.rp];

        ctl_d = ctl_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];

        new_wp = ptr_sel ? ctl_q.wp : ptr_wdata[PTR_W-1:0];
        new_rp = ptr_sel ? ptr_wdata[PTR_W-1:0] : ctl_q.rp;

        if (ptr_we) begin
            if (!ptr_bad) begin
                ctl_d.wp  = new_wp;
                ctl_d.rp  = new_rp;
                ctl_d.cnt = {1'b0, new_wp - new_rp};
            end
        end else begin
            if (push_ok) begin
                mem_d[ctl_q.wp] = push_entry;
                ctl_d.wp        = ctl_q.wp + 1'b1;
            end
            if (pop_ok) begin
                ctl_d.rp = ctl_q.rp + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
                2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
                default: ctl_d.cnt = ctl_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    // R2: the held count never exceeds the storage
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_W'(DEPTH));

    // R2: a push into a full FIFO without a pop leaves it full
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cnt == CNT_W'(DEPTH)) && push_en && !pop_req && !ptr_we
        |=> ctl_q.cnt == CNT_W'(DEPTH));

    // R6: a stalled read removes nothing
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && (ctl_q.cnt == '0) && !push_en && !ptr_we
        |=> ctl_q.cnt == '0);

    // R4: an out-of-range load leaves both pointers where they were
    a_r4_bad_ptr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we && (ptr_wdata >= PTR_IN_W'(DEPTH))
        |=> $stable(ctl_q.wp) && $stable(ctl_q.rp));

endmodule

// File: rtl/ep_sticky_flags.sv
module ep_sticky_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_i,
    input  logic [N_FLAGS-1:0] clr_i,
    input  logic [N_FLAGS-1:0] mask_i,
    output logic [N_FLAGS-1:0] flag_o,
    output logic               err_o
);
    typedef struct packed {
        logic [N_FLAGS-1:0] flag;
        logic               err;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_FLAGS; i++) begin
            // a set in the same cycle as a clear wins
            st_d.flag[i] = set_i[i] | (st_q.flag[i] & ~clr_i[i]);
        end
        st_d.err = |(st_q.flag & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign err_o  = st_q.err;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_chk
        // R7: a flag holds while no clearing write arrives
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.flag[g] && !clr_i[g] |=> st_q.flag[g]);
        // R7: a clearing write without a set drops the flag
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[g] && !set_i[g] |=> !st_q.flag[g]);
        // R8: a set always lands, even against a clear
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> st_q.flag[g]);
        // R9: an unmasked flag reaches the error output one edge later
        a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.flag[g] && !mask_i[g] |=> st_q.err);
    end

    // R9: with every flag clear or masked, the error output drops
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.flag & ~mask_i) == '0) |=> !st_q.err);

endmodule

// File: rtl/ep_frame_lane.sv
module ep_frame_lane
    import ep_fsr_pkg::*;
(
    input  logic       head_valid,
    input  logic       head_eof,
    input  logic [1:0] head_lane,
    output logic [3:0] frm
);
    always_comb begin
        if (head_valid && head_eof) frm = lane_onehot(head_lane);
        else                        frm = 4'b0000;
    end
endmodule

// File: rtl/ep_fifo_status.sv
module ep_fifo_status
    import ep_fsr_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int PTR_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_en,
    input  logic [31:0]         push_data,
    input  logic                push_eof,
    input  logic [1:0]          push_lane,
    input  logic                pop_req,
    output logic [31:0]         pop_data,
    output logic                pop_ok,
    output logic                pop_wait,
    input  logic                ptr_we,
    input  logic                ptr_sel,
    input  logic [PTR_IN_W-1:0] ptr_wdata,
    input  logic                stat_we,
    input  logic [31:0]         stat_wdata,
    input  logic                mask_bad_ptr,
    input  logic                mask_starve,
    output logic [31:0]         status,
    output logic                fifo_err
);
    localparam int N_FLAGS = 2;
    localparam int F_BAD   = 0;
    localparam int F_STV   = 1;

    fifo_entry_t        push_entry, head;
    logic               empty, ptr_bad;
    logic [3:0]         frm;
    logic [N_FLAGS-1:0] set_v, clr_v, mask_v, flags;

    assign push_entry = '{data: push_data, eof: push_eof, lane: push_lane};

    ep_fifo_store #(.DEPTH(DEPTH), .PTR_IN_W(PTR_IN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_entry (push_entry),
        .pop_req    (pop_req),
        .ptr_we     (ptr_we),
        .ptr_sel    (ptr_sel),
        .ptr_wdata  (ptr_wdata),
        .head       (head),
        .empty      (empty),
        .pop_ok     (pop_ok),
        .ptr_bad    (ptr_bad)
    );

    always_comb begin
        pop_wait       = pop_req && empty;
        set_v[F_BAD]   = ptr_bad;
        set_v[F_STV]   = pop_wait;
        clr_v[F_BAD]   = stat_we && stat_wdata[BIT_BAD_PTR];
        clr_v[F_STV]   = stat_we && stat_wdata[BIT_STARVE];
        mask_v[F_BAD]  = mask_bad_ptr;
        mask_v[F_STV]  = mask_starve;
    end

    ep_sticky_flags #(.N_FLAGS(N_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .mask_i (mask_v),
        .flag_o (flags),
        .err_o  (fifo_err)
    );

    ep_frame_lane u_lane (
        .head_valid (!empty),
        .head_eof   (head.eof),
        .head_lane  (head.lane),
        .frm        (frm)
    );

    always_comb begin
        pop_data                  = head.data;
        status                    = '0;
        status[BIT_BAD_PTR]       = flags[F_BAD];
        status[BIT_STARVE]        = flags[F_STV];
        status[FRM_LSB +: 4]      = frm;
        status[BIT_EMPTY]         = empty;
    end

    // R10: the frame-lane code is one-hot or zero
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[FRM_LSB +: 4]));

    // R3 / R10: an empty FIFO shows no frame lane
    a_r3_empty_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
        status[BIT_EMPTY] |-> status[FRM_LSB +: 4] == 4'b0000);

    // R6: a stalled read is never also served
    a_r6_wait_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_wait && pop_ok));

endmodule

// File: tb/tb_ep_fifo_status.sv
module tb_ep_fifo_status;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int PTR_IN_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_en = 0, push_eof = 0, pop_req = 0, ptr_we = 0, ptr_sel = 0;
    logic stat_we = 0, mask_bad_ptr = 0, mask_starve = 0;
    logic [31:0] push_data = '0, stat_wdata = '0;
    logic [1:0]  push_lane = '0;
    logic [PTR_IN_W-1:0] ptr_wdata = '0;
    logic [31:0] pop_data, status;
    logic pop_ok, pop_wait, fifo_err;

    int n_chk = 0;
    int n_fail = 0;
    int wp_m;

    ep_fifo_status #(.DEPTH(DEPTH), .PTR_IN_W(PTR_IN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_data(push_data), .push_eof(push_eof), .push_lane(push_lane),
        .pop_req(pop_req), .pop_data(pop_data), .pop_ok(pop_ok), .pop_wait(pop_wait),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .mask_bad_ptr(mask_bad_ptr), .mask_starve(mask_starve),
        .status(status), .fifo_err(fifo_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int i);
        return 32'hC0DE_0000 | (i * 32'h0000_0111);
    endfunction

    function automatic logic [3:0] lane_exp(input int i);
        // word i: frame end when i is odd, lane i[2:1]
        return (i % 2 == 1) ? (4'b0001 << ((i / 2) % 4)) : 4'b0000;
    endfunction

    task automatic r11_zero();
        chk("R11 reserved bits", status & 32'h30FE_FFFF, 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        rst_n = 1'b1;
        #1;
        chk("R1 status reset", status, 32'h0001_0000);
        chk("R1 err reset", {31'b0, fifo_err}, 32'h0);
        chk("R1 pop_ok reset", {31'b0, pop_ok}, 32'h0);

        // fill with every eof/lane combination
        for (int i = 0; i < DEPTH; i++) begin
            push_en = 1; push_data = word_of(i);
            push_eof = (i % 2 == 1); push_lane = 2'((i / 2) % 4);
            step();
            chk("R3 not empty after push", {31'b0, status[16]}, 32'h0);
        end
        push_data = 32'hDEAD_BEEF; push_eof = 1; push_lane = 2'd3;
        step();
        push_en = 0;

        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 head order", pop_data, word_of(i));
            chk("R10 frame lane", {28'b0, status[27:24]}, {28'b0, lane_exp(i)});
            r11_zero();
            pop_req = 1; #1;
            chk("R2 pop served", {31'b0, pop_ok}, 32'h1);
            step();
            pop_req = 0;
        end
        chk("R2 full push dropped / R3 empty", {31'b0, status[16]}, 32'h1);
        chk("R10 empty lane zero", {28'b0, status[27:24]}, 32'h0);

        // starved read
        pop_req = 1; #1;
        chk("R6 wait comb", {31'b0, pop_wait}, 32'h1);
        chk("R6 no serve", {31'b0, pop_ok}, 32'h0);
        step();
        pop_req = 0;
        chk("R6 flag set", {31'b0, status[30]}, 32'h1);
        chk("R6 still empty", {31'b0, status[16]}, 32'h1);
        chk("R9 err not yet", {31'b0, fifo_err}, 32'h0);
        step();
        chk("R9 err one edge later", {31'b0, fifo_err}, 32'h1);

        stat_we = 1; stat_wdata = 32'h8000_0000;
        step();
        chk("R7 zero keeps flag", {31'b0, status[30]}, 32'h1);
        stat_wdata = 32'h4000_0000;
        step();
        stat_we = 0;
        chk("R7 one clears flag", {31'b0, status[30]}, 32'h0);
        step();
        chk("R9 err falls", {31'b0, fifo_err}, 32'h0);

        // sweep every write-pointer load value (read pointer is 0)
        wp_m = 0;
        for (int v = 0; v < 256; v++) begin
            ptr_we = 1; ptr_sel = 0; ptr_wdata = 8'(v);
            step();
            ptr_we = 0;
            if (v < DEPTH) wp_m = v;
            chk("R4 bad-pointer flag", {31'b0, status[31]}, {31'b0, (v >= DEPTH)});
            chk("R5 count via empty", {31'b0, status[16]}, {31'b0, (wp_m == 0)});
            if (v >= DEPTH) begin
                stat_we = 1; stat_wdata = 32'h8000_0000;
                step();
                stat_we = 0;
                chk("R7 clear bad-pointer", {31'b0, status[31]}, 32'h0);
            end
        end
        step(); step();
        chk("R9 err idle", {31'b0, fifo_err}, 32'h0);

        // write pointer 7, read pointer 0: seven held words, data kept
        for (int i = 0; i < 3; i++) begin
            chk("R5 data kept", pop_data, word_of(i));
            chk("R10 lane after load", {28'b0, status[27:24]}, {28'b0, lane_exp(i)});
            pop_req = 1;
            step();
            pop_req = 0;
        end
        ptr_we = 1; ptr_sel = 1; ptr_wdata = 8'd7;
        push_en = 1; push_data = 32'h1234_5678;
        step();
        ptr_we = 0; push_en = 0;
        chk("R5 equal pointers empty, push ignored", {31'b0, status[16]}, 32'h1);

        // set against clear
        ptr_we = 1; ptr_wdata = 8'd200; stat_we = 1; stat_wdata = 32'h8000_0000;
        step();
        chk("R8 set wins from clear", {31'b0, status[31]}, 32'h1);
        step();
        chk("R8 set wins while set", {31'b0, status[31]}, 32'h1);
        ptr_we = 0;
        pop_req = 1; stat_wdata = 32'h4000_0000;
        step();
        pop_req = 0; stat_we = 0;
        chk("R8 starve set wins", {31'b0, status[30]}, 32'h1);

        for (int m = 0; m < 4; m++) begin
            mask_bad_ptr = m[0]; mask_starve = m[1];
            step();
            chk("R9 both flags mask sweep", {31'b0, fifo_err}, {31'b0, !(m[0] && m[1])});
        end
        stat_we = 1; stat_wdata = 32'h4000_0000;
        step();
        stat_we = 0;
        for (int m = 0; m < 4; m++) begin
            mask_bad_ptr = m[0]; mask_starve = m[1];
            step();
            chk("R9 bad-pointer only mask sweep", {31'b0, fifo_err}, {31'b0, !m[0]});
        end
        mask_bad_ptr = 0; mask_starve = 0;
        stat_we = 1; stat_wdata = 32'hC000_0000;
        step();
        stat_we = 0;
        chk("R7 both cleared", status, 32'h0001_0000);
        step();
        chk("R9 err clear", {31'b0, fifo_err}, 32'h0);
        finish_run();
    end
endmodule